// File: doc/BRIEF.md
# Battery-Domain Seconds Counter with Alarm

This block keeps time in a always-on domain clocked by a 32.768 kHz oscillator. A 47-bit counter advances once per slow tick. Its bottom 15 bits hold the fraction of a second and its top 32 bits hold whole seconds. A one-word alarm register is compared against the seconds field. When the seconds value steps onto the alarm value, a sticky alarm flag is set. The flag can drive an interrupt line that wakes the system.

Software reaches the block over a simple single-cycle register bus in a separate, faster clock domain. All crossings are handled inside the block. Control levels pass through two-flop synchronizers into the slow domain, and their effective values are synchronized back for read-back. The counter crosses to the bus domain as a Gray-coded copy. Alarm events cross as a toggle. Because of this, software sets or clears an enable and then polls the read-back until it matches. It loads the counter only while the counter is stopped, and it reads a running counter twice until two reads agree. The fixed-pattern guard register is plain 32-bit storage that software initializes.

Top module: `rtc_lp_alarm`

## Requirements
- R1: While running, the counter advances by exactly one per slow-clock tick, with carry from the 15 fraction bits into the seconds field and wrap from all ones to zero. Seconds are counter bits 46:15. Offset 0x20 reads counter bits 31:0. Offset 0x1C reads bits 46:32 in its bits 14:0 and zero above.
- R2: While the counter is stopped, writing offset 0x20 and then offset 0x1C loads the counter from those two words. A stopped counter keeps its value.
- R3: Writes to offsets 0x20 and 0x1C are ignored while the run bit is set or its read-back still shows 1.
- R4: Control at offset 0x04 works as follows. Bit 0 is run, bit 1 is alarm compare enable and bit 3 is wakeup enable. Bits 0 and 1 read back the value the slow domain is actually using, so a read right after a write still shows the old value. Bit 3 reads back directly. All other bits read zero.
- R5: Status bit 0 at offset 0x18 sets exactly once, on the tick where the seconds field changes to equal the alarm seconds at offset 0x24, while run and alarm compare are both in effect. A counter that already equals the alarm value does not set it.
- R6: With alarm compare off, a seconds value stepping onto the alarm value does not set the flag.
- R7: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. An alarm event in the same cycle as a clear wins.
- R8: The irq output is high exactly when the alarm flag and control bit 3 are both set.
- R9: Offsets 0x24 (alarm seconds) and 0x30 (guard word, initialized by software to 0x41736166) read back the last 32-bit value written. Unmapped offsets read zero.
- R10: After reset, every register reads zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Register bus clock |
| rst_bus_n | input | 1 | Asynchronous active-low reset, bus domain |
| bus_wr | input | 1 | Write strobe, one bus cycle |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata after the next clk_bus edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Alarm interrupt / wakeup request |
| clk_slow | input | 1 | 32.768 kHz counting clock |
| rst_slow_n | input | 1 | Asynchronous active-low reset, slow domain |

## Verification
A wrong fraction carry or a missed wrap makes the seconds read back after a stop differ from the loaded value plus the run time, within a few dozen slow ticks. A compare that tests equality rather than arrival, or that ignores the alarm enable, shows up as a status bit that is set when it should not be, or set one second late. The bench catches this because it waits a bounded window and then reads status, so a late event counts as a miss. A broken read-back synchronizer or lock shows at once: the control word read right after a write shows the new value, or a write made during running changes the seconds read after the stop.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int RTC_CNT_W  = 47;
  localparam int RTC_FRAC_W = 15;
  localparam int RTC_DATA_W = 32;
  localparam int RTC_ADDR_W = 8;

  localparam logic [7:0] OFS_CTRL   = 8'h04;
  localparam logic [7:0] OFS_STAT   = 8'h18;
  localparam logic [7:0] OFS_CNT_HI = 8'h1C;
  localparam logic [7:0] OFS_CNT_LO = 8'h20;
  localparam logic [7:0] OFS_ALARM  = 8'h24;
  localparam logic [7:0] OFS_GUARD  = 8'h30;

  localparam int CTL_RUN  = 0;
  localparam int CTL_ALM  = 1;
  localparam int CTL_WAKE = 3;

  function automatic logic [63:0] bin_to_gray(input logic [63:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [63:0] gray_to_bin(input logic [63:0] g);
    logic [63:0] b;
    b[63] = g[63];
    for (int i = 62; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [31:0] secs_of(input logic [63:0] c, input int frac_w);
    return 32'(c >> frac_w);
  endfunction

endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= stg[g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rtc_slow_core.sv
module rtc_slow_core
  import rtc_pkg::*;
#(
  parameter int CNT_W  = RTC_CNT_W,
  parameter int FRAC_W = RTC_FRAC_W,
  parameter int SEC_W  = CNT_W - FRAC_W
) (
  input  logic             clk_slow,
  input  logic             rst_slow_n,
  input  logic             run_req_a,
  input  logic             alm_req_a,
  input  logic             load_tgl_a,
  input  logic [CNT_W-1:0] load_val,
  input  logic [SEC_W-1:0] alarm_sec,
  output logic             run_s,
  output logic             alm_s,
  output logic [CNT_W-1:0] cnt_gray,
  output logic             fire_tgl
);
  logic [2:0]       req_s;
  logic             load_s;
  logic             load_prev;
  logic             load_evt;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;
  logic [SEC_W-1:0] sec_now;
  logic [SEC_W-1:0] sec_nxt;
  logic             match_evt;

  rtc_sync #(.W(3), .STAGES(2)) u_req_sync (
    .clk   (clk_slow),
    .rst_n (rst_slow_n),
    .d     ({load_tgl_a, alm_req_a, run_req_a}),
    .q     (req_s)
  );

  assign run_s    = req_s[0];
  assign alm_s    = req_s[1];
  assign load_s   = req_s[2];
  assign load_evt = load_s ^ load_prev;

  assign cnt_inc  = cnt + CNT_W'(1);
  assign sec_now  = SEC_W'(secs_of(64'(cnt), FRAC_W));
  assign sec_nxt  = SEC_W'(secs_of(64'(cnt_inc), FRAC_W));

  // arrival at the alarm second, not mere equality
  assign match_evt = run_s && alm_s && !load_evt &&
                     (sec_nxt == alarm_sec) && (sec_now != alarm_sec);

  always_ff @(posedge clk_slow or negedge rst_slow_n) begin
    if (!rst_slow_n) begin
      cnt       <= '0;
      load_prev <= 1'b0;
      fire_tgl  <= 1'b0;
      cnt_gray  <= '0;
    end else begin
      load_prev <= load_s;
      if (load_evt)   cnt <= load_val;
      else if (run_s) cnt <= cnt_inc;
      if (match_evt)  fire_tgl <= ~fire_tgl;
      cnt_gray <= CNT_W'(bin_to_gray(64'(cnt)));
    end
  end

  // R1
  run_step_chk: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
    run_s && !load_evt |=> cnt == $past(cnt) + CNT_W'(1));

  // R2
  stop_hold_chk: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
    !run_s && !load_evt |=> $stable(cnt));

  // R5
  fire_on_match_chk: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
    !$stable(fire_tgl) |-> SEC_W'(secs_of(64'(cnt), FRAC_W)) == alarm_sec);

  // R6
  fire_gated_chk: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
    !$stable(fire_tgl) |-> $past(alm_s));

endmodule

// File: rtl/rtc_bus_regs.sv
module rtc_bus_regs
  import rtc_pkg::*;
#(
  parameter int CNT_W  = RTC_CNT_W,
  parameter int FRAC_W = RTC_FRAC_W,
  parameter int DATA_W = RTC_DATA_W,
  parameter int ADDR_W = RTC_ADDR_W,
  parameter int SEC_W  = CNT_W - FRAC_W,
  parameter int HI_W   = CNT_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              run_s_a,
  input  logic              alm_s_a,
  input  logic [CNT_W-1:0]  cnt_gray_a,
  input  logic              fire_tgl_a,
  output logic              ctrl_run,
  output logic              ctrl_alm,
  output logic              load_tgl,
  output logic [CNT_W-1:0]  load_val,
  output logic [SEC_W-1:0]  alarm_sec
);
  logic [2:0]        back_s;
  logic              run_rb;
  logic              alm_rb;
  logic              fire_s;
  logic              fire_prev;
  logic              fire_evt;
  logic [CNT_W-1:0]  gray_b;
  logic [CNT_W-1:0]  cnt_b;
  logic              ctrl_wake;
  logic              flag;
  logic [DATA_W-1:0] stage_lo;
  logic [HI_W-1:0]   stage_hi;
  logic [DATA_W-1:0] guard_q;
  logic              cnt_locked;
  logic              wr_ctrl, wr_stat, wr_lo, wr_hi, wr_alarm, wr_guard;
  logic [DATA_W-1:0] rd_mux;

  rtc_sync #(.W(3), .STAGES(2)) u_back_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({fire_tgl_a, alm_s_a, run_s_a}),
    .q     (back_s)
  );

  rtc_sync #(.W(CNT_W), .STAGES(2)) u_gray_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cnt_gray_a),
    .q     (gray_b)
  );

  assign run_rb   = back_s[0];
  assign alm_rb   = back_s[1];
  assign fire_s   = back_s[2];
  assign fire_evt = fire_s ^ fire_prev;
  assign cnt_b    = CNT_W'(gray_to_bin(64'(gray_b)));

  assign cnt_locked = ctrl_run || run_rb;

  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_stat  = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
  assign wr_lo    = bus_wr && (bus_addr == ADDR_W'(OFS_CNT_LO)) && !cnt_locked;
  assign wr_hi    = bus_wr && (bus_addr == ADDR_W'(OFS_CNT_HI)) && !cnt_locked;
  assign wr_alarm = bus_wr && (bus_addr == ADDR_W'(OFS_ALARM));
  assign wr_guard = bus_wr && (bus_addr == ADDR_W'(OFS_GUARD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_run  <= 1'b0;
      ctrl_alm  <= 1'b0;
      ctrl_wake <= 1'b0;
      flag      <= 1'b0;
      fire_prev <= 1'b0;
      stage_lo  <= '0;
      stage_hi  <= '0;
      load_tgl  <= 1'b0;
      alarm_sec <= '0;
      guard_q   <= '0;
    end else begin
      fire_prev <= fire_s;
      if (wr_ctrl) begin
        ctrl_run  <= bus_wdata[CTL_RUN];
        ctrl_alm  <= bus_wdata[CTL_ALM];
        ctrl_wake <= bus_wdata[CTL_WAKE];
      end
      if (fire_evt)                flag <= 1'b1;
      else if (wr_stat && bus_wdata[0]) flag <= 1'b0;
      if (wr_lo) stage_lo <= bus_wdata;
      if (wr_hi) begin
        stage_hi <= bus_wdata[HI_W-1:0];
        load_tgl <= ~load_tgl;
      end
      if (wr_alarm) alarm_sec <= SEC_W'(bus_wdata);
      if (wr_guard) guard_q   <= bus_wdata;
    end
  end

  assign load_val = {stage_hi, stage_lo};
  assign irq      = flag && ctrl_wake;

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(OFS_CTRL):   rd_mux = DATA_W'({ctrl_wake, 1'b0, alm_rb, run_rb});
      ADDR_W'(OFS_STAT):   rd_mux = DATA_W'(flag);
      ADDR_W'(OFS_CNT_HI): rd_mux = DATA_W'(cnt_b[CNT_W-1:DATA_W]);
      ADDR_W'(OFS_CNT_LO): rd_mux = cnt_b[DATA_W-1:0];
      ADDR_W'(OFS_ALARM):  rd_mux = DATA_W'(alarm_sec);
      ADDR_W'(OFS_GUARD):  rd_mux = guard_q;
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;

  // R5
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(fire_evt));

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat && bus_wdata[0] && !fire_evt |=> !flag);

  // R3
  load_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && cnt_locked &&
    (bus_addr == ADDR_W'(OFS_CNT_LO) || bus_addr == ADDR_W'(OFS_CNT_HI))
    |=> $stable(load_val) && $stable(load_tgl));

endmodule

// File: rtl/rtc_lp_alarm.sv
module rtc_lp_alarm
  import rtc_pkg::*;
#(
  parameter int CNT_W  = RTC_CNT_W,
  parameter int FRAC_W = RTC_FRAC_W,
  parameter int DATA_W = RTC_DATA_W,
  parameter int ADDR_W = RTC_ADDR_W
) (
  input  logic              clk_bus,
  input  logic              rst_bus_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              clk_slow,
  input  logic              rst_slow_n
);
  localparam int SEC_W = CNT_W - FRAC_W;

  logic             ctrl_run, ctrl_alm, load_tgl;
  logic [CNT_W-1:0] load_val;
  logic [SEC_W-1:0] alarm_sec;
  logic             run_s, alm_s, fire_tgl;
  logic [CNT_W-1:0] cnt_gray;

  rtc_bus_regs #(
    .CNT_W(CNT_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk        (clk_bus),
    .rst_n      (rst_bus_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq        (irq),
    .run_s_a    (run_s),
    .alm_s_a    (alm_s),
    .cnt_gray_a (cnt_gray),
    .fire_tgl_a (fire_tgl),
    .ctrl_run   (ctrl_run),
    .ctrl_alm   (ctrl_alm),
    .load_tgl   (load_tgl),
    .load_val   (load_val),
    .alarm_sec  (alarm_sec)
  );

  rtc_slow_core #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_core (
    .clk_slow   (clk_slow),
    .rst_slow_n (rst_slow_n),
    .run_req_a  (ctrl_run),
    .alm_req_a  (ctrl_alm),
    .load_tgl_a (load_tgl),
    .load_val   (load_val),
    .alarm_sec  (alarm_sec),
    .run_s      (run_s),
    .alm_s      (alm_s),
    .cnt_gray   (cnt_gray),
    .fire_tgl   (fire_tgl)
  );
endmodule

// File: tb/tb_rtc_lp_alarm.sv
module tb_rtc_lp_alarm;
  logic        clk_bus = 1'b0;
  logic        clk_slow = 1'b0;
  logic        rst_bus_n = 1'b0;
  logic        rst_slow_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;

  always #2.5 clk_bus = ~clk_bus;
  always #20  clk_slow = ~clk_slow;

  rtc_lp_alarm dut (
    .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .clk_slow(clk_slow), .rst_slow_n(rst_slow_n)
  );

  // {offset, write data, expected read}
  localparam logic [71:0] VEC [0:6] = '{
    {8'h24, 32'h12345678, 32'h12345678},
    {8'h24, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {8'h30, 32'h00000000, 32'h00000000},
    {8'h30, 32'h41736166, 32'h41736166},
    {8'h04, 32'h00000008, 32'h00000008},
    {8'h04, 32'h00000004, 32'h00000000},
    {8'h08, 32'hDEADBEEF, 32'h00000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_bus);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk_bus);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_bus);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk_bus);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic slow_wait(input int n);
    repeat (n) @(posedge clk_slow);
    @(negedge clk_bus);
  endtask

  task automatic ctrl_set(input logic [31:0] v);
    logic [31:0] d;
    bit ok = 0;
    wr(8'h04, v);
    for (int i = 0; i < 200 && !ok; i++) begin
      rd(8'h04, d);
      ok = (d[1:0] == v[1:0]);
    end
    chk("R4 read-back settles", d, v & 32'h0000000B);
  endtask

  task automatic load_cnt(input logic [31:0] sec, input logic [14:0] frac);
    wr(8'h20, {sec[16:0], frac});
    wr(8'h1C, {17'd0, sec[31:17]});
    slow_wait(6);
  endtask

  task automatic read_secs(output logic [31:0] s, output logic [31:0] hi, output logic [31:0] lo);
    rd(8'h1C, hi);
    rd(8'h20, lo);
    s = {hi[14:0], lo[31:15]};
  endtask

  initial begin
    repeat (150000) @(posedge clk_bus);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d, s, hi, lo;
    logic [31:0] sec_a;
    sec_a = 32'hABCD1234;

    repeat (20) @(negedge clk_bus);
    rst_bus_n = 1'b1; rst_slow_n = 1'b1;
    repeat (4) @(negedge clk_bus);

    // R10 reset state
    rd(8'h04, d); chk("R10 ctrl", d, 0);
    rd(8'h18, d); chk("R10 status", d, 0);
    rd(8'h1C, d); chk("R10 cnt hi", d, 0);
    rd(8'h20, d); chk("R10 cnt lo", d, 0);
    rd(8'h24, d); chk("R10 alarm", d, 0);
    rd(8'h30, d); chk("R10 guard", d, 0);
    chk("R10 irq", 32'(irq), 0);

    // register table: R9 storage, R4 reserved bits
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], d);
      chk((VEC[i][71:64] == 8'h04) ? "R4 table" : "R9 table", d, VEC[i][31:0]);
    end

    // R2 load while stopped, R1 field placement
    load_cnt(sec_a, 15'h0100);
    read_secs(s, hi, lo);
    chk("R1 hi field", hi, {17'd0, sec_a[31:17]});
    chk("R2 lo load", lo, {sec_a[16:0], 15'h0100});
    slow_wait(10);
    rd(8'h20, d); chk("R2 stopped hold", d, {sec_a[16:0], 15'h0100});

    // R4 run bit lags the write
    wr(8'h04, 32'h1);
    rd(8'h04, d); chk("R4 run not yet in effect", d, 0);
    ctrl_set(32'h1);
    slow_wait(20);
    // R3 writes while running ignored
    wr(8'h20, 32'h0);
    wr(8'h1C, 32'h0);
    wr(8'h04, 32'h0);
    rd(8'h04, d); chk("R4 stop not yet in effect", d, 32'h1);
    ctrl_set(32'h0);
    read_secs(s, hi, lo);
    chk("R3 running write ignored", s, sec_a);
    chk("R1 fraction advanced", 32'(lo[14:0] > 15'h0100), 1);

    // R5 alarm on arrival, with wakeup
    load_cnt(sec_a, 15'h7FF8);
    wr(8'h24, sec_a + 1);
    wr(8'h04, 32'hB);
    rd(8'h04, d); chk("R4 wake direct", d, 32'h8);
    ctrl_set(32'hB);
    slow_wait(40);
    rd(8'h18, d); chk("R5 flag set", d, 1);
    chk("R8 irq with wake", 32'(irq), 1);
    ctrl_set(32'h8);
    read_secs(s, hi, lo);
    chk("R5 fired at seconds step", s, sec_a + 1);

    // R7 write-one-to-clear
    wr(8'h18, 32'h0);
    rd(8'h18, d); chk("R7 write 0 keeps flag", d, 1);
    wr(8'h18, 32'hFFFFFFFF);
    rd(8'h18, d); chk("R7 clear", d, 0);
    chk("R8 irq drops", 32'(irq), 0);

    // R5 no refire while already equal
    ctrl_set(32'hB);
    slow_wait(40);
    rd(8'h18, d); chk("R5 once only", d, 0);
    ctrl_set(32'h8);

    // R8 gating by wake bit
    load_cnt(sec_a, 15'h7FF8);
    ctrl_set(32'h3);
    slow_wait(40);
    rd(8'h18, d); chk("R8 flag without wake", d, 1);
    chk("R8 irq masked", 32'(irq), 0);
    wr(8'h04, 32'hB);
    @(negedge clk_bus);
    chk("R8 irq unmasked", 32'(irq), 1);
    ctrl_set(32'h0);
    wr(8'h18, 32'h1);

    // R6 compare off
    load_cnt(sec_a, 15'h7FF8);
    ctrl_set(32'h9);
    slow_wait(40);
    rd(8'h18, d); chk("R6 no flag", d, 0);
    chk("R6 no irq", 32'(irq), 0);
    ctrl_set(32'h8);
    read_secs(s, hi, lo);
    chk("R6 counter passed alarm", s, sec_a + 1);

    // R1 wrap to zero with alarm at 0
    ctrl_set(32'h0);
    load_cnt(32'hFFFFFFFF, 15'h7FF8);
    wr(8'h24, 32'h0);
    ctrl_set(32'h3);
    slow_wait(40);
    rd(8'h18, d); chk("R5 flag at wrap", d, 1);
    ctrl_set(32'h0);
    read_secs(s, hi, lo);
    chk("R1 wrap seconds", s, 0);
    chk("R1 wrap hi", hi, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule